// File: doc/BRIEF.md
# SPI Frame Shift Engine

This is a master-mode serial shifter that moves one frame through an SPI link. A start strobe hands it a parallel transmit word and a control word. It then sends the frame out on the serial data output, most significant bit first, and captures the serial data input at the same time. At the end it returns the captured bits as a parallel word, together with a one-cycle done strobe.

The block does not divide the clock itself. An external divider supplies a one-cycle enable pulse, and each pulse that arrives while a frame is active produces one serial-clock edge. The control word is latched when a start is accepted, so it can change freely while a frame runs. The control word selects:

- the clock idle level;
- the clock phase, meaning which edge drives the data and which edge samples it;
- the frame length, from 4 to 16 bits;
- an internal loopback, in which the receiver listens to the block's own transmit line.

Chip select, FIFOs and rate selection are all handled outside the block.

Top module: `spi_frame_shifter`

## Requirements
- R1: After reset, sclk_o, mosi_o, busy_o and done_o are 0 and rx_word_o is 0.
- R2: When start_i is high and busy_o is low, the frame is accepted and busy_o is high in the next cycle. A start_i that arrives while busy_o is high has no effect on the running frame or on its result.
- R3: SCLK idles at the level of cfg_i[4] (polarity), taken from the latched control word. The level is valid from the cycle after an accepted start. During a frame of N bits, SCLK toggles exactly 2N times and finishes at the idle level.
- R4: With cfg_i[5]=0 (phase 0), mosi_o shows the frame's most significant bit from the cycle after the start. The next bit appears on each trailing edge, and the input is sampled on each leading edge.
- R5: With cfg_i[5]=1 (phase 1), each bit is driven on a leading edge and sampled on the following trailing edge.
- R6: Bits leave and arrive most significant first. Only the low N bits of tx_word_i are sent. rx_word_o holds the N received bits right-aligned, with zeros above them.
- R7: cfg_i[3:0] holds the frame length minus one, so values 3 to 15 give 4 to 16 bits. Values 0 to 2 give a 4-bit frame.
- R8: With cfg_i[6]=1 (loopback), the receiver samples the block's own mosi_o and ignores miso_i. rx_word_o then equals the low N bits of the transmit word.
- R9: done_o is high for exactly one cycle, namely the cycle after the final SCLK edge of a frame. busy_o is low in that same cycle, and rx_word_o is updated then and held until the next frame ends.
- R10: A clock edge needs sclk_en_i. Pulses that arrive while idle are ignored. In a busy cycle that follows a cycle with no pulse, sclk_o and mosi_o do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_en_i | input | 1 | One-cycle tick from the external rate divider; one tick gives one SCLK edge |
| start_i | input | 1 | Starts a frame when the block is idle |
| cfg_i | input | 7 | Control word: [3:0] length minus one, [4] polarity, [5] phase, [6] loopback |
| tx_word_i | input | 16 | Transmit word, right-aligned |
| miso_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| busy_o | output | 1 | High while a frame is active |
| done_o | output | 1 | One-cycle end-of-frame strobe |
| rx_word_o | output | 16 | Received word, right-aligned and zero-extended |

## Verification
Every output is registered, so results have fixed delays:

- busy_o and the initial SCLK/MOSI levels appear one cycle after an accepted start.
- Each SCLK or MOSI change appears one cycle after the cycle that carried its tick.
- done_o and the new rx_word_o appear one cycle after the tick of the final edge.
- done_o falls one cycle after that.

The bench drives every input on the falling clock edge and reads the outputs on the next falling edge. A tick set before an edge is therefore checked exactly one rising edge later. The bench also reads mosi_o just before each sampling edge, at the moment a slave would capture it. It counts SCLK toggles across frames that have idle gaps between ticks.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;
  parameter int unsigned SIZE_W = 4;
  parameter int unsigned DATA_W = 2 ** SIZE_W;
  parameter int unsigned CNT_W  = SIZE_W + 1;

  typedef struct packed {
    logic              loopback;
    logic              cpha;
    logic              cpol;
    logic [SIZE_W-1:0] size_m1;
  } frame_cfg_t;

  // frame length minus one, with short codes raised to the floor
  function automatic logic [SIZE_W-1:0] eff_m1(logic [SIZE_W-1:0] code,
                                                logic [SIZE_W-1:0] floor_m1);
    return (code < floor_m1) ? floor_m1 : code;
  endfunction
endpackage

// File: rtl/spi_edge_seq.sv
module spi_edge_seq
  import spi_shift_pkg::*;
#(
  parameter int unsigned MIN_BITS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sclk_en_i,
  input  frame_cfg_t        cfg_i,
  output logic              load_o,
  output logic [SIZE_W-1:0] load_m1_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              drive_o,
  output logic              sample_o,
  output logic              finish_o,
  output logic              loopback_o
);
  localparam logic [SIZE_W-1:0] FLOOR_M1 = SIZE_W'(MIN_BITS - 1);

  logic              busy_q, done_q, sclk_q, cpha_q, loop_q;
  logic [CNT_W-1:0]  edge_q;
  logic [SIZE_W-1:0] m1_q;
  logic [CNT_W-1:0]  last_edge;
  logic              tick, last, odd;

  assign load_o    = start_i & ~busy_q;
  assign load_m1_o = eff_m1(cfg_i.size_m1, FLOOR_M1);
  assign tick      = busy_q & sclk_en_i;
  assign last_edge = {m1_q, 1'b1};
  assign last      = (edge_q == last_edge);
  assign odd       = edge_q[0];

  // even edge index = leading edge, odd = trailing edge
  assign drive_o  = tick & (cpha_q ? ~odd : (odd & ~last));
  assign sample_o = tick & (cpha_q ? odd : ~odd);
  assign finish_o = tick & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      cpha_q <= 1'b0;
      loop_q <= 1'b0;
      edge_q <= '0;
      m1_q   <= FLOOR_M1;
    end else begin
      done_q <= finish_o;
      if (load_o) begin
        busy_q <= 1'b1;
        edge_q <= '0;
        sclk_q <= cfg_i.cpol;
        cpha_q <= cfg_i.cpha;
        loop_q <= cfg_i.loopback;
        m1_q   <= load_m1_o;
      end else if (tick) begin
        sclk_q <= ~sclk_q;
        edge_q <= edge_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign sclk_o     = sclk_q;
  assign loopback_o = loop_q;
endmodule

// File: rtl/spi_tx_path.sv
module spi_tx_path
  import spi_shift_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              cpha_i,
  input  logic [SIZE_W-1:0] m1_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              drive_i,
  output logic              mosi_o
);
  logic [DATA_W-1:0] tx_q;
  logic [SIZE_W-1:0] ptr_q;
  logic              mosi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      ptr_q  <= '0;
      mosi_q <= 1'b0;
    end else if (load_i) begin
      tx_q <= word_i;
      if (cpha_i) begin
        mosi_q <= 1'b0;
        ptr_q  <= m1_i;
      end else begin
        // phase 0: first bit must be on the line before the first edge
        mosi_q <= word_i[m1_i];
        ptr_q  <= m1_i - 1'b1;
      end
    end else if (drive_i) begin
      mosi_q <= tx_q[ptr_q];
      ptr_q  <= ptr_q - 1'b1;
    end
  end

  assign mosi_o = mosi_q;
endmodule

// File: rtl/spi_rx_path.sv
module spi_rx_path
  import spi_shift_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              sample_i,
  input  logic              finish_i,
  input  logic              serial_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] sh_q, word_q, sh_nxt;

  assign sh_nxt = {sh_q[DATA_W-2:0], serial_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      word_q <= '0;
    end else begin
      if (load_i)        sh_q <= '0;
      else if (sample_i) sh_q <= sh_nxt;
      // phase 1 samples on the final edge itself
      if (finish_i) word_q <= sample_i ? sh_nxt : sh_q;
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_shift_pkg::*;
#(
  parameter int unsigned MIN_BITS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_en_i,
  input  logic              start_i,
  input  logic [6:0]        cfg_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_word_o
);
  frame_cfg_t        cfg;
  logic              load, drive, sample, finish, loopback, serial_in;
  logic [SIZE_W-1:0] load_m1;

  assign cfg = frame_cfg_t'(cfg_i);

  spi_edge_seq #(.MIN_BITS(MIN_BITS)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .sclk_en_i (sclk_en_i),
    .cfg_i     (cfg),
    .load_o    (load),
    .load_m1_o (load_m1),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .sclk_o    (sclk_o),
    .drive_o   (drive),
    .sample_o  (sample),
    .finish_o  (finish),
    .loopback_o(loopback)
  );

  spi_tx_path i_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .cpha_i (cfg.cpha),
    .m1_i   (load_m1),
    .word_i (tx_word_i),
    .drive_i(drive),
    .mosi_o (mosi_o)
  );

  assign serial_in = loopback ? mosi_o : miso_i;

  spi_rx_path i_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .sample_i(sample),
    .finish_i(finish),
    .serial_i(serial_in),
    .word_o  (rx_word_o)
  );
endmodule

// File: rtl/spi_frame_shifter_chk.sv
module spi_frame_shifter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic sclk_en_i,
  input logic sclk_o,
  input logic mosi_o,
  input logic busy_o,
  input logic done_o
);
  a_r2_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r3_idle_sclk_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> $stable(sclk_o));

  a_r10_no_tick_no_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$past(sclk_en_i)) |-> $stable(sclk_o));

  a_r10_no_tick_mosi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$past(sclk_en_i)) |-> $stable(mosi_o));
endmodule

bind spi_frame_shifter spi_frame_shifter_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .sclk_en_i(sclk_en_i),
  .sclk_o   (sclk_o),
  .mosi_o   (mosi_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/test_spi_frame_shifter.sv
`timescale 1ns/1ps
module test_spi_frame_shifter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk_en_i = 1'b0;
  logic        start_i = 1'b0;
  logic [6:0]  cfg_i = '0;
  logic [15:0] tx_word_i = '0;
  logic        miso_i = 1'b0;
  logic        sclk_o, mosi_o, busy_o, done_o;
  logic [15:0] rx_word_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  spi_frame_shifter i_spi_frame_shifter (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_en_i(sclk_en_i), .start_i(start_i),
    .cfg_i(cfg_i), .tx_word_i(tx_word_i), .miso_i(miso_i), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .busy_o(busy_o), .done_o(done_o), .rx_word_o(rx_word_o)
  );

  // {cfg, tx, slave word, tick gap}
  localparam int NV = 9;
  localparam logic [47:0] VEC [NV] = '{
    {8'h07, 16'h00A5, 16'h003C, 8'd1},
    {8'h17, 16'h005A, 16'h00C3, 8'd2},
    {8'h27, 16'h0081, 16'h007E, 8'd3},
    {8'h3F, 16'hBEEF, 16'h1234, 8'd1},
    {8'h03, 16'hFFF9, 16'hFFF6, 8'd2},
    {8'h01, 16'h000B, 16'h0005, 8'd1},
    {8'h4A, 16'h05A5, 16'h0000, 8'd2},
    {8'h7F, 16'hC0DE, 16'hFFFF, 8'd1},
    {8'h2C, 16'h1ABC, 16'h0F0F, 8'd2}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [6:0] cfg, input logic [15:0] tx,
                           input logic [15:0] sl, input int gap, input bit probe);
    int          n;
    bit          cpol, cpha, lp, smp;
    logic [16:0] mask;
    logic [15:0] exp_rx, got_mosi;
    int          toggles, k;
    logic        prev;
    n        = (cfg[3:0] < 4'd3) ? 4 : int'(cfg[3:0]) + 1;
    cpol     = cfg[4];
    cpha     = cfg[5];
    lp       = cfg[6];
    mask     = (17'd1 << n) - 17'd1;
    exp_rx   = lp ? (tx & mask[15:0]) : (sl & mask[15:0]);
    got_mosi = '0;
    toggles  = 0;
    k        = 0;
    @(negedge clk_i);
    start_i = 1'b1; cfg_i = cfg; tx_word_i = tx;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    chk(sclk_o == cpol, "R3 idle level at start", sclk_o, cpol);
    if (!cpha) chk(mosi_o == tx[n-1], "R4 msb before first edge", mosi_o, tx[n-1]);
    prev = sclk_o;
    for (int e = 0; e < 2 * n; e++) begin
      for (int g = 1; g < gap; g++) begin
        @(negedge clk_i);
        chk(sclk_o == prev, "R10 no edge without tick", sclk_o, prev);
      end
      smp = cpha ? e[0] : !e[0];
      if (smp) begin
        miso_i   = lp ? ~sl[n-1-k] : sl[n-1-k];
        got_mosi = {got_mosi[14:0], mosi_o};
        k++;
      end
      if (probe && e == 2) begin
        start_i = 1'b1; tx_word_i = ~tx; cfg_i = cfg ^ 7'h30;
      end
      sclk_en_i = 1'b1;
      @(negedge clk_i);
      sclk_en_i = 1'b0;
      start_i   = 1'b0;
      if (sclk_o != prev) toggles++;
      prev = sclk_o;
      if (e != 2 * n - 1) chk(busy_o == 1'b1, "R9 busy through frame", busy_o, 1);
    end
    chk(done_o == 1'b1, "R9 done after last edge", done_o, 1);
    chk(busy_o == 1'b0, "R9 busy drops with done", busy_o, 0);
    chk(rx_word_o == exp_rx, lp ? "R8 loopback word" : "R6 received word", rx_word_o, exp_rx);
    chk(sclk_o == cpol, "R3 sclk back at idle", sclk_o, cpol);
    chk(toggles == 2 * n, "R3 edge count", toggles, 2 * n);
    chk(got_mosi == (tx & mask[15:0]), cpha ? "R5 mosi bits at sampling edges" :
        "R4 mosi bits at sampling edges", got_mosi, tx & mask[15:0]);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R9 done single cycle", done_o, 0);
    chk(rx_word_o == exp_rx, "R9 result held", rx_word_o, exp_rx);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(sclk_o == 1'b0, "R1 reset sclk", sclk_o, 0);
    chk(mosi_o == 1'b0, "R1 reset mosi", mosi_o, 0);
    chk(busy_o == 1'b0, "R1 reset busy", busy_o, 0);
    chk(done_o == 1'b0, "R1 reset done", done_o, 0);
    chk(rx_word_o == 16'h0, "R1 reset rx word", rx_word_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    sclk_en_i = 1'b1;
    repeat (5) @(negedge clk_i);
    sclk_en_i = 1'b0;
    chk(sclk_o == 1'b0, "R10 idle ticks ignored sclk", sclk_o, 0);
    chk(busy_o == 1'b0, "R10 idle ticks ignored busy", busy_o, 0);

    for (int v = 0; v < NV; v++)
      run_frame(VEC[v][46:40], VEC[v][39:24], VEC[v][23:8], int'(VEC[v][7:0]), 1'b0);

    // R7 clamp: code 0 behaves as 4 bits
    run_frame(7'h00, 16'h0006, 16'h0009, 1, 1'b0);
    // R2 start during a frame is ignored
    run_frame(7'h07, 16'h0096, 16'h0069, 2, 1'b1);
    run_frame(7'h2F, 16'h8001, 16'h7FFE, 1, 1'b1);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule